// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block takes a stereo pair of parallel PCM samples and sends it out on a three-wire audio link: a bit clock, a word-select clock and one serial data line. Both clocks are derived from the system clock by a fixed divider. Every stereo frame is 64 bit-clock periods long, with 32 for each channel. The bit clock does not depend on the sample width.

A two-bit format input selects where a sample sits inside its 32-bit slot. Standard I2S places the MSB one bit-clock after the word-select edge. Left-justified places the MSB on the first bit-clock. Right-justified ends the LSB on the last bit-clock of the slot. A word-length input selects 16, 20 or 24 significant bits. Data is always sent MSB first.

The sample source offers a left/right pair with a valid/ready handshake. The transmitter accepts a pair only as a new frame starts. If no pair is offered at that point, it sends the previous pair again. The format and word length are captured at the same frame boundary.

Top module: `aud_ser_tx`

## Requirements
- R1: The bit clock toggles every HALF_DIV system clocks. Word select completes one full period every 64 bit-clock periods, whatever the word length or format.
- R2: Word select is low for the left slot and high for the right slot. Word select and serial data change only in the system cycle in which the bit clock falls.
- R3: In standard mode (format 0, and format 3 treated the same way), bit-clock 0 of each slot carries zero. The sample's MSB is on bit-clock 1, followed by the remaining bits MSB first.
- R4: In left-justified mode (format 1), the sample's MSB is on bit-clock 0 of the slot, followed by the remaining bits MSB first.
- R5: In right-justified mode (format 2), the LSB is on bit-clock 31 of the slot and the MSB is on bit-clock 32 minus the word length. Every earlier bit-clock of the slot carries the sample's sign bit.
- R6: In standard and left-justified modes, every bit-clock of a slot after the LSB carries zero.
- R7: Word length code 0 selects 16 bits, code 1 selects 20 bits, and codes 2 and 3 select 24 bits. The sample occupies the low bits of its 24-bit input, and input bits above the word length have no effect on the serial data.
- R8: A change of format or word length in the middle of a frame has no effect until the next frame begins.
- R9: in_ready is high for exactly one system cycle per frame: the cycle whose clock edge starts bit-clock 0 of the left slot. A pair is taken when in_valid and in_ready are both high in that cycle.
- R10: A frame that starts without a valid pair repeats the previously accepted pair. This is a pair of zeros if no pair has been accepted since reset.
- R11: During reset, the bit clock and word select are high, and serial data and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Framing: 0 standard, 1 left-justified, 2 right-justified, 3 standard |
| wlen | input | 2 | Word length: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | MAX_W | Left sample, right-aligned two's complement |
| in_right | input | MAX_W | Right sample, right-aligned two's complement |
| in_ready | output | 1 | Pair taken in this cycle if in_valid is high |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (low = left) |
| sdata | output | 1 | Serial data, changes on the falling bit-clock edge |

## Verification
The hardest case to reach from the ports is a format or word-length change landing in the middle of a frame while the slot in flight uses the old framing. The stimulus changes both inputs at varied points partway through a frame, before it offers the next pair. The reference model builds each frame's 64 expected bits only at the frame boundary, so any early switch shows up as a serial-data mismatch. Frames with no valid pair are mixed in to exercise repetition. Random upper input bits and random signs exercise masking and sign filling.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int HALF_DIV  = 2,
  parameter int MAX_W     = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wlen,
  input  logic             in_valid,
  input  logic [MAX_W-1:0] in_left,
  input  logic [MAX_W-1:0] in_right,
  output logic             in_ready,
  output logic             bclk,
  output logic             ws,
  output logic             sdata
);
  localparam int FRAME = 2 * SLOT_BITS;
  localparam int PW    = $clog2(FRAME);
  localparam int CW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IW    = $clog2(MAX_W);

  logic [CW-1:0]    div_q;
  logic             bclk_q, ws_q, sd_q;
  logic [PW-1:0]    pos_q;
  logic [MAX_W-1:0] hl_q, hr_q;
  logic [1:0]       fmt_q, wl_q;

  logic tick, fall, wrap, take;
  logic [PW-1:0]    pos_n;
  logic [MAX_W-1:0] nl, nr, word;
  logic [1:0]       nfmt, nwl;
  logic             ch, bit_n;

  assign tick  = (div_q == CW'(HALF_DIV - 1));
  assign fall  = tick & bclk_q;
  assign pos_n = pos_q + 1'b1;
  assign wrap  = fall && (pos_q == PW'(FRAME - 1));
  assign take  = wrap & in_valid;
  assign nl    = take ? in_left  : hl_q;
  assign nr    = take ? in_right : hr_q;
  assign nfmt  = wrap ? fmt  : fmt_q;
  assign nwl   = wrap ? wlen : wl_q;
  assign ch    = pos_n[PW-1];
  assign word  = ch ? nr : nl;

  function automatic int wbits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic pick(input logic [MAX_W-1:0] w, input logic [1:0] f,
                                input int len, input int s);
    int off, k;
    if (f == 2'd2) begin
      if (s >= SLOT_BITS - len) return w[IW'(SLOT_BITS - 1 - s)];
      return w[IW'(len - 1)];
    end
    off = (f == 2'd1) ? 0 : 1;
    k   = s - off;
    if (k >= 0 && k < len) return w[IW'(len - 1 - k)];
    return 1'b0;
  endfunction

  assign bit_n = pick(word, nfmt, wbits(nwl), int'(pos_n[PW-2:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b1;
      ws_q   <= 1'b1;
      sd_q   <= 1'b0;
      pos_q  <= PW'(FRAME - 1);
      hl_q   <= '0;
      hr_q   <= '0;
      fmt_q  <= '0;
      wl_q   <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (fall) begin
        pos_q <= pos_n;
        ws_q  <= ch;
        sd_q  <= bit_n;
        hl_q  <= nl;
        hr_q  <= nr;
        fmt_q <= nfmt;
        wl_q  <= nwl;
      end
    end
  end

  assign in_ready = wrap;
  assign bclk     = bclk_q;
  assign ws       = ws_q;
  assign sdata    = sd_q;

  logic [PW:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (fall) begin
      if (!ws_q && ch) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !ws_q && ch && seen_q) |-> (gap_q == (PW+1)'(FRAME - 1)));
  p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bclk));
  p_sd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(fmt_q) && $stable(wl_q)));
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  p_pair_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(hl_q) && $stable(hr_q)));
endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_ready, bclk, ws, sdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ser_tx #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
    .bclk(bclk), .ws(ws), .sdata(sdata));

  int mcnt = 0, mbclk = 1, mpos = 63, mfmt = 0, mwl = 0;
  logic [23:0] ml = '0, mr = '0;
  logic mbits [64];
  logic msd = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial foreach (mbits[i]) mbits[i] = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mcnt == HALF - 1) begin
        mcnt = 0;
        if (mbclk == 1) begin
          mbclk = 0;
          mpos = (mpos + 1) % 64;
          if (mpos == 0) begin
            int w;
            if (in_valid) begin ml = in_left; mr = in_right; end
            mfmt = fmt; mwl = wlen;
            w = (mwl == 0) ? 16 : (mwl == 1) ? 20 : 24;
            for (int c = 0; c < 2; c++) begin
              logic [23:0] v;
              v = (c == 0) ? ml : mr;
              for (int i = 0; i < 32; i++) begin
                int first;
                first = (mfmt == 2) ? 32 - w : (mfmt == 1) ? 0 : 1;
                if (i < first) mbits[c*32+i] = (mfmt == 2) ? v[w-1] : 1'b0;
                else if (i - first < w) mbits[c*32+i] = v[w-1-(i-first)];
                else mbits[c*32+i] = 1'b0;
              end
            end
          end
          msd = mbits[mpos];
        end else mbclk = 1;
      end else mcnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rdy;
      string tg;
      exp_rdy = (mcnt == HALF - 1) && (mbclk == 1) && (mpos == 63);
      tg = (mfmt == 2) ? "R5 R7 R8 R10 sdata" : (mfmt == 1) ? "R4 R6 R7 R8 R10 sdata"
                                                            : "R3 R6 R7 R8 R10 sdata";
      chk(bclk == mbclk[0], "R1 bclk", bclk, mbclk);
      chk(ws == (mpos >= 32), "R2 ws", ws, mpos >= 32);
      chk(sdata == msd, tg, sdata, msd);
      chk(in_ready == exp_rdy, "R9 in_ready", in_ready, exp_rdy);
    end
  end

  task automatic wait_boundary(input bit offer);
    in_valid = offer;
    do @(negedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bclk == 1'b1, "R11 bclk reset", bclk, 1);
    chk(ws == 1'b1, "R11 ws reset", ws, 1);
    chk(sdata == 1'b0, "R11 sdata reset", sdata, 0);
    chk(in_ready == 1'b0, "R11 ready reset", in_ready, 0);
    rst_n = 1'b1;
    wait_boundary(1'b0);
    for (int i = 0; i < 20; i++) begin
      repeat (37 + 11 * i) @(negedge clk);
      fmt  = 2'(i % 4);
      wlen = 2'((i / 4) % 4);
      in_left  = 24'($urandom);
      in_right = 24'($urandom);
      if (i == 2) begin in_left = 24'h7F_8001; in_right = 24'hFF_8000; end
      wait_boundary((i % 5) != 3);
    end
    wait_boundary(1'b0);
    wait_boundary(1'b0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    finish_run();
  end
endmodule